// File: doc/BRIEF.md
# Outbound Address Window Decoder

This block sits between an internal-bus master and the request path of a serial link. Every valid internal-bus access is compared against five outbound windows. Four of them are memory windows of 4 GB each, and one is an I/O window of 64 KB. Because every window has a fixed size, a hit depends only on the upper address bits matching the window's programmable base. There are no limit registers.

For each accepted access the block reports, one cycle later:
- whether it hit,
- which window hit,
- which link transaction type to issue, and
- whether the access must be refused with a target abort.

A narrow write port reloads any base register. Packet building, data transfer and link signalling are handled elsewhere.

Top module: `obw_decoder`

## Requirements
- R1: After reset, memory window k (k = 0..3) has upper base k+1, so it claims addresses whose bits [35:32] equal k+1. The I/O window base is 0_FFFD_0000h, so it claims 0_FFFD_0000h to 0_FFFD_FFFFh.
- R2: A memory window hits when address bits [35:32] equal its 4-bit base. The reported window index is 0 to 3 for the memory windows.
- R3: The I/O window hits when address bits [35:16] equal its 20-bit base. The reported window index is 4.
- R4: A memory-window hit reports kind 1 (memory read) for a read and kind 2 (memory write) for a write.
- R5: An I/O-window hit reports kind 3 (I/O read) for a read and kind 4 (I/O write) for a write.
- R6: An I/O-window read crosses a dword when address bits [1:0] plus the length field (byte count minus one, 3 bits) exceed 3. Such a read reports abort=1, hit=1, index 4 and kind 0, so no request is issued. An I/O write that crosses a dword is not aborted.
- R7: When several windows match, the I/O window wins. Among memory windows, the lowest index wins.
- R8: An access that matches no window reports hit=0, index 0, kind 0 and abort=0.
- R9: A base write takes effect on the cycle after the write strobe. A decode sampled in the same cycle as the write still uses the old base. A select value of 0 to 3 writes memory base k from data bits [3:0]. A select value of 4 writes the I/O base from data bits [19:0]. Select values 5 to 7 are ignored.
- R10: The decode outputs are registered. A request strobed at one clock edge appears with dec_valid=1 after that edge. A cycle with no strobe gives dec_valid=0 with all other outputs zero.
- R11: dec_be carries the request's byte enables only when a link request is issued (kind not 0). Otherwise dec_be is zero.
- R12: During and immediately after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Base register write strobe |
| cfg_sel | input | 3 | Register select: 0-3 memory bases, 4 I/O base |
| cfg_wdata | input | 20 | Base value to write |
| req_valid | input | 1 | Internal-bus access strobe |
| req_addr | input | 36 | Internal-bus byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte enables for lanes 3:0 |
| req_len | input | 3 | Access length in bytes minus one |
| dec_valid | output | 1 | Decode result present |
| dec_hit | output | 1 | Some window claimed the access |
| dec_win | output | 3 | Index of the claiming window |
| dec_kind | output | 3 | Link transaction type |
| dec_abort | output | 1 | Target abort for a dword-crossing I/O read |
| dec_be | output | 4 | Forwarded byte enables |

## Verification
Every decode result is due exactly one clock edge after its strobe. The bench drives inputs on a falling edge and reads the outputs on the next falling edge, so exactly one rising edge lies between stimulus and check. A base write uses the same one-edge latency. A request presented together with a write is therefore predicted against the old base, and the following request against the new base. The idle cycle after each request is also checked, to confirm the outputs fall back to zero.

// File: rtl/obw_pkg.sv
// Package: shared encodings for the outbound window decoder.
// Assumes: link kind codes are consumed by the downstream request builder.
package obw_pkg;
    typedef enum logic [2:0] {
        LK_NONE   = 3'd0,
        LK_MEM_RD = 3'd1,
        LK_MEM_WR = 3'd2,
        LK_IO_RD  = 3'd3,
        LK_IO_WR  = 3'd4
    } link_kind_e;
endpackage

// File: rtl/obw_base_regs.sv
// Module: obw_base_regs
// Holds the memory window upper-base registers and the I/O window base.
// Memory window k resets to k+1; the I/O base resets to IO_BASE_RST.
// Assumes: cfg_sel 0..MEM_WIN-1 picks a memory base, MEM_WIN picks the
// I/O base, anything higher is dropped.
module obw_base_regs #(
    parameter int MEM_WIN     = 4,
    parameter int UB_W        = 4,
    parameter int IOB_W       = 20,
    parameter int SEL_W       = 3,
    parameter logic [IOB_W-1:0] IO_BASE_RST = 20'h0FFFD
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [SEL_W-1:0]                cfg_sel,
    input  logic [IOB_W-1:0]                cfg_wdata,
    output logic [MEM_WIN-1:0][UB_W-1:0]    mem_base_o,
    output logic [IOB_W-1:0]                io_base_o
);

    genvar k;
    generate
        for (k = 0; k < MEM_WIN; k++) begin : g_mem
            // Load memory base k on its own select, else hold.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem_base_o[k] <= UB_W'(k + 1);
                else if (cfg_we && (cfg_sel == SEL_W'(k)))
                    mem_base_o[k] <= cfg_wdata[UB_W-1:0];
            end

            p_wr_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && cfg_sel == SEL_W'(k)) |=> (mem_base_o[k] == $past(cfg_wdata[UB_W-1:0])));
        end
    endgenerate

    // Load the I/O base on its select, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            io_base_o <= IO_BASE_RST;
        else if (cfg_we && (cfg_sel == SEL_W'(MEM_WIN)))
            io_base_o <= cfg_wdata;
    end

    p_io_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_sel == SEL_W'(MEM_WIN)) |=> $stable(io_base_o));

endmodule

// File: rtl/obw_window_match.sv
// Module: obw_window_match
// Compares the upper address bits with every window base and resolves
// overlaps by fixed priority: I/O window first, then memory 0 upward.
// Assumes: addr_hi carries address bits [ADDR_W-1:IO_LOG2].
module obw_window_match #(
    parameter int ADDR_W  = 36,
    parameter int IO_LOG2 = 16,
    parameter int MEM_WIN = 4,
    parameter int UB_W    = ADDR_W - 32,
    parameter int IOB_W   = ADDR_W - IO_LOG2,
    parameter int WIN_W   = $clog2(MEM_WIN + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IOB_W-1:0]             addr_hi,
    input  logic [MEM_WIN-1:0][UB_W-1:0] mem_base,
    input  logic [IOB_W-1:0]             io_base,
    output logic                         hit,
    output logic                         is_io,
    output logic [WIN_W-1:0]             win_idx
);

    logic [MEM_WIN-1:0] mem_eq;
    logic               io_eq;
    logic [MEM_WIN:0]   grant;

    genvar k;
    generate
        for (k = 0; k < MEM_WIN; k++) begin : g_cmp
            assign mem_eq[k] = (addr_hi[IOB_W-1 -: UB_W] == mem_base[k]);
        end
    endgenerate

    assign io_eq = (addr_hi == io_base);

    // Pick one winner: the I/O window, else the lowest matching memory window.
    always_comb begin
        grant   = '0;
        win_idx = '0;
        if (io_eq) begin
            grant[MEM_WIN] = 1'b1;
            win_idx        = WIN_W'(MEM_WIN);
        end else begin
            for (int i = MEM_WIN - 1; i >= 0; i--) begin
                if (mem_eq[i]) begin
                    grant   = '0;
                    grant[i] = 1'b1;
                    win_idx = WIN_W'(i);
                end
            end
        end
    end

    assign hit   = |grant;
    assign is_io = grant[MEM_WIN];

    p_one_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_io_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        io_eq |-> is_io);

endmodule

// File: rtl/obw_cmd_xlate.sv
// Module: obw_cmd_xlate
// Turns a window hit plus the bus direction into a link request kind,
// and refuses I/O reads whose last byte leaves the starting dword.
// Assumes: len is the byte count minus one.
module obw_cmd_xlate
    import obw_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  logic             hit,
    input  logic             is_io,
    input  logic             wr,
    input  logic [1:0]       addr_lo,
    input  logic [LEN_W-1:0] len,
    output link_kind_e       kind,
    output logic             abort
);

    localparam int SUM_W = ((LEN_W > 2) ? LEN_W : 2) + 1;

    logic [SUM_W-1:0] last_off;
    logic             crosses;

    assign last_off = SUM_W'(addr_lo) + SUM_W'(len);
    assign crosses  = (last_off > SUM_W'(3));

    // Map hit type and direction to a kind; abort dword-crossing I/O reads.
    always_comb begin
        kind  = LK_NONE;
        abort = 1'b0;
        if (hit) begin
            if (is_io) begin
                if (!wr && crosses)
                    abort = 1'b1;
                else
                    kind = wr ? LK_IO_WR : LK_IO_RD;
            end else begin
                kind = wr ? LK_MEM_WR : LK_MEM_RD;
            end
        end
    end

endmodule

// File: rtl/obw_decoder.sv
// Module: obw_decoder (top)
// Decodes internal-bus accesses against four fixed 4 GB memory windows
// and one fixed 64 KB I/O window, registering hit, window index, link
// request kind, abort and byte enables one cycle after req_valid.
// Assumes: a request and a base write in the same cycle see the old base.
module obw_decoder
    import obw_pkg::*;
#(
    parameter int ADDR_W  = 36,
    parameter int IO_LOG2 = 16,
    parameter int MEM_WIN = 4,
    parameter int LEN_W   = 3,
    parameter int BE_W    = 4,
    parameter int SEL_W   = 3,
    parameter logic [ADDR_W-IO_LOG2-1:0] IO_BASE_RST = 20'h0FFFD
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [SEL_W-1:0]               cfg_sel,
    input  logic [ADDR_W-IO_LOG2-1:0]      cfg_wdata,
    input  logic                           req_valid,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic                           req_write,
    input  logic [BE_W-1:0]                req_be,
    input  logic [LEN_W-1:0]               req_len,
    output logic                           dec_valid,
    output logic                           dec_hit,
    output logic [$clog2(MEM_WIN+1)-1:0]   dec_win,
    output logic [2:0]                     dec_kind,
    output logic                           dec_abort,
    output logic [BE_W-1:0]                dec_be
);

    localparam int UB_W   = ADDR_W - 32;
    localparam int IOB_W  = ADDR_W - IO_LOG2;
    localparam int WIN_W  = $clog2(MEM_WIN + 1);
    localparam logic [WIN_W-1:0] IO_IDX = WIN_W'(MEM_WIN);

    logic [MEM_WIN-1:0][UB_W-1:0] mem_base;
    logic [IOB_W-1:0]             io_base;
    logic                         hit_c;
    logic                         is_io_c;
    logic [WIN_W-1:0]             win_c;
    link_kind_e                   kind_c;
    logic                         abort_c;
    logic                         unused_mid;

    assign unused_mid = ^req_addr[IO_LOG2-1:2];

    obw_base_regs #(
        .MEM_WIN(MEM_WIN), .UB_W(UB_W), .IOB_W(IOB_W),
        .SEL_W(SEL_W), .IO_BASE_RST(IO_BASE_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mem_base_o(mem_base), .io_base_o(io_base)
    );

    obw_window_match #(
        .ADDR_W(ADDR_W), .IO_LOG2(IO_LOG2), .MEM_WIN(MEM_WIN),
        .UB_W(UB_W), .IOB_W(IOB_W), .WIN_W(WIN_W)
    ) u_match (
        .clk(clk), .rst_n(rst_n),
        .addr_hi(req_addr[ADDR_W-1:IO_LOG2]),
        .mem_base(mem_base), .io_base(io_base),
        .hit(hit_c), .is_io(is_io_c), .win_idx(win_c)
    );

    obw_cmd_xlate #(.LEN_W(LEN_W)) u_xlate (
        .hit(hit_c), .is_io(is_io_c), .wr(req_write),
        .addr_lo(req_addr[1:0]), .len(req_len),
        .kind(kind_c), .abort(abort_c)
    );

    // Register the decode result for one cycle after each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_hit   <= 1'b0;
            dec_win   <= '0;
            dec_kind  <= 3'd0;
            dec_abort <= 1'b0;
            dec_be    <= '0;
        end else begin
            dec_valid <= req_valid;
            dec_hit   <= req_valid & hit_c;
            dec_win   <= req_valid ? win_c : '0;
            dec_kind  <= req_valid ? kind_c : LK_NONE;
            dec_abort <= req_valid & abort_c;
            dec_be    <= (req_valid && kind_c != LK_NONE) ? req_be : '0;
        end
    end

    p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dec_valid);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!dec_valid && !dec_hit && dec_kind == 3'd0 && !dec_abort));

    p_abort_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_abort |-> (dec_hit && dec_win == IO_IDX && dec_kind == 3'd0));

    p_miss_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_hit) |-> (dec_kind == 3'd0 && !dec_abort && dec_win == '0));

    p_io_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_hit && dec_win == IO_IDX && !dec_abort) |->
            (dec_kind == 3'd3 || dec_kind == 3'd4));

    p_mem_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_hit && dec_win < IO_IDX) |-> (dec_kind == 3'd1 || dec_kind == 3'd2));

    p_be_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_kind == 3'd0) |-> (dec_be == '0));

endmodule

// File: tb/obw_decoder_tb.sv
// Bench for obw_decoder: directed corners, then seeded random traffic,
// each result predicted from a bench-side copy of the window bases.
module obw_decoder_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [19:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [35:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [3:0]  req_be = '0;
    logic [2:0]  req_len = '0;
    logic        dec_valid, dec_hit, dec_abort;
    logic [2:0]  dec_win, dec_kind;
    logic [3:0]  dec_be;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [3:0]  m_base [4];
    logic [19:0] m_io;

    always #(CLK_PERIOD/2) clk = ~clk;

    obw_decoder u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_be(req_be), .req_len(req_len),
        .dec_valid(dec_valid), .dec_hit(dec_hit), .dec_win(dec_win),
        .dec_kind(dec_kind), .dec_abort(dec_abort), .dec_be(dec_be)
    );

    // Packed prediction: {valid, hit, win[2:0], kind[2:0], abort, be[3:0]}
    function automatic logic [12:0] predict(input logic [35:0] a, input logic wr,
                                            input logic [3:0] be, input logic [2:0] len);
        logic       h = 1'b0, ab = 1'b0;
        logic [2:0] w = '0, kd = '0;
        if (a[35:16] == m_io) begin
            h = 1'b1; w = 3'd4;
            if (!wr && (int'(a[1:0]) + int'(len) > 3)) ab = 1'b1;
            else kd = wr ? 3'd4 : 3'd3;
        end else begin
            for (int i = 3; i >= 0; i--)
                if (a[35:32] == m_base[i]) begin
                    h = 1'b1; w = 3'(i); kd = wr ? 3'd2 : 3'd1;
                end
        end
        return {1'b1, h, w, kd, ab, (kd != 3'd0) ? be : 4'd0};
    endfunction

    task automatic check(input string req, input logic [12:0] exp);
        logic [12:0] act = {dec_valid, dec_hit, dec_win, dec_kind, dec_abort, dec_be};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got v%0b h%0b w%0d k%0d a%0b be%h expected v%0b h%0b w%0d k%0d a%0b be%h",
                     req, act[12], act[11], act[10:8], act[7:5], act[4], act[3:0],
                     exp[12], exp[11], exp[10:8], exp[7:5], exp[4], exp[3:0]);
        end
    endtask

    // Drive one request, check it one edge later, then check the idle cycle (R10).
    task automatic access(input logic [35:0] a, input logic wr, input logic [3:0] be,
                          input logic [2:0] len, input string req);
        logic [12:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_be = be; req_len = len;
        exp = predict(a, wr, be, len);
        @(negedge clk);
        req_valid = 1'b0;
        check(req, exp);
        @(negedge clk);
        check("R10 idle", 13'd0);
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [19:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel < 3'd4) m_base[sel] = d[3:0];
        else if (sel == 3'd4) m_io = d;
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        logic [12:0] exp;
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) m_base[i] = 4'(i + 1);
        m_io = 20'h0FFFD;
        repeat (3) @(negedge clk);
        check("R12 in reset", 13'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 after reset", 13'd0);

        // R1/R2/R4: default memory sections
        access(36'h1_0000_1000, 1'b0, 4'hF, 3'd3, "R1 R4 mem0 read");
        access(36'h2_8000_0004, 1'b1, 4'h3, 3'd1, "R2 R4 mem1 write");
        access(36'h3_FFFF_FFFC, 1'b0, 4'h8, 3'd0, "R2 mem2 read");
        access(36'h4_1234_5678, 1'b1, 4'h5, 3'd7, "R1 R4 mem3 write");
        // R1/R3/R5: default I/O window edges
        access(36'h0_FFFD_0000, 1'b0, 4'h1, 3'd0, "R1 R5 io read low edge");
        access(36'h0_FFFD_FFFC, 1'b1, 4'hC, 3'd3, "R3 R5 io write high edge");
        // R8: misses
        access(36'h0_FFFE_0000, 1'b0, 4'hF, 3'd0, "R8 above io window");
        access(36'h0_FFFC_FFFF, 1'b1, 4'hF, 3'd0, "R8 below io window");
        access(36'h5_0000_0000, 1'b0, 4'hF, 3'd0, "R8 section 5");
        // R6: dword crossing
        access(36'h0_FFFD_0102, 1'b0, 4'hC, 3'd2, "R6 io read crosses");
        access(36'h0_FFFD_0101, 1'b0, 4'hE, 3'd2, "R6 io read ends at byte 3");
        access(36'h0_FFFD_0103, 1'b1, 4'h8, 3'd4, "R6 io write crosses no abort");
        access(36'h0_FFFD_0100, 1'b0, 4'hF, 3'd4, "R6 io read 5 bytes");
        access(36'h1_0000_0003, 1'b0, 4'hF, 3'd7, "R6 mem read crossing not aborted");

        // R9: write and request in the same cycle use the old base
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd1; cfg_wdata = 20'h00009;
        req_valid = 1'b1; req_addr = 36'h9_0000_0040; req_write = 1'b0;
        req_be = 4'hF; req_len = 3'd3;
        exp = predict(req_addr, 1'b0, 4'hF, 3'd3);
        m_base[1] = 4'h9;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check("R9 same-cycle old base", exp);
        access(36'h9_0000_0040, 1'b0, 4'hF, 3'd3, "R9 new base next cycle");
        access(36'h2_0000_0040, 1'b0, 4'hF, 3'd3, "R9 old section released");
        // R9: ignored select values
        cfg_write(3'd6, 20'h00002);
        cfg_write(3'd7, 20'h12345);
        access(36'h2_0000_0000, 1'b1, 4'hF, 3'd0, "R9 sel 6 ignored");
        access(36'h0_FFFD_0010, 1'b1, 4'hF, 3'd0, "R9 sel 7 ignored");
        // R7: overlapping windows
        cfg_write(3'd2, 20'h00009);
        access(36'h9_1111_0000, 1'b1, 4'h6, 3'd1, "R7 lower memory index wins");
        cfg_write(3'd4, 20'h1_2345);
        access(36'h1_2345_0010, 1'b0, 4'hF, 3'd3, "R7 io beats mem0");
        access(36'h1_2346_0010, 1'b0, 4'hF, 3'd3, "R7 mem0 outside io range");
        access(36'h0_FFFD_0010, 1'b0, 4'hF, 3'd3, "R9 old io base released");

        // Seeded random mix, R2 R3 R4 R5 R6 R8 R11
        for (int n = 0; n < 400; n++) begin
            logic [35:0] a;
            int pick = $urandom_range(0, 3);
            if (n % 50 == 0) cfg_write(3'($urandom_range(0, 5)), 20'($urandom));
            a = {$urandom, $urandom};
            if (pick == 0) a[35:16] = m_io;
            else if (pick == 1) a[35:32] = m_base[$urandom_range(0, 3)];
            access(a, 1'($urandom), 4'($urandom), 3'($urandom), "R11 random R2 R3 R5 R6 R8");
        end

        finish_up();
    end

endmodule